// File: doc/BRIEF.md
# Frame Check Sequence CRC-16 Engine

This block computes a 16-bit frame check sequence for serial infrared framing. A host reaches it through a small register port with a 16-bit data path. Software first clears the engine by writing to the control register. It then pushes the frame one byte per write into the data register. At any point it can read two things: how many bytes have gone in, from the low bits of the control register, and the current check value, from the output register. A fourth address is reserved. It reads as zero and ignores writes.

The accumulator uses the generator x^16+x^12+x^5+1 and shifts bits in least-significant first, so the per-bit feedback constant is 0x8408. The preset is 0x0000, and the output view is the accumulator XORed with 0xFCDE. With these constants, the byte sequence 0xCC, 0xF5, 0xF1, 0xA7 after a clear gives 0x51DF. Software uses that value as a power-on self-test. Each byte is folded in one clock cycle, so back-to-back writes stream at full rate.

Sequencing is a two-state machine. IDLE holds the accumulator. ABSORB folds the byte latched on the previous edge and bumps the count.

The transitions are:
- IDLE goes to ABSORB on a data write.
- ABSORB stays in ABSORB on a further data write.
- ABSORB returns to IDLE when no data write arrives.
- A clear write forces IDLE from either state.

Top module: `fcs_crc_engine`

## Requirements
- R1: A write to the control register (address 0) with bit 15 set reloads the accumulator with 0x0000 and clears the count; from the next clock edge the count reads 0 and the output reads 0xFCDE. A control write with bit 15 clear changes nothing.
- R2: A read of the control register returns the byte count in bits 11:0 and zero in bits 15:12.
- R3: A write to the data register (address 1) folds only bits 7:0 into the check value; bits 15:8 of the write have no effect on the result.
- R4: Each data write adds exactly one to the count. Count and output reflect the write from the second rising edge after it. Writes on consecutive cycles are each absorbed, one per cycle.
- R5: The count stops at 0xFFF; further data writes leave it at 0xFFF while the check value keeps updating.
- R6: After a clear, writing 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and an output of 0x51DF.
- R7: The check value follows the reflected x^16+x^12+x^5+1 update (feedback 0x8408, LSB first) from preset 0x0000. The output register (address 3) is the accumulator XOR 0xFCDE.
- R8: The reserved register (address 2) always reads 0x0000, and writes to it change neither count nor output.
- R9: Read data is a combinational view of the selected register, valid in the same cycle as the read address.
- R10: After the asynchronous active-low reset, the count reads 0 and the output reads 0xFCDE.
- R11: A clear written on the cycle right after a data write wins over that pending byte: count 0 and output 0xFCDE follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index (0 control, 1 data, 2 reserved, 3 output) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 16 | Read data for rd_addr |

## Verification
The bench targets several corner cases. Each is chosen because a specific mistake would show up there:
- Self-test vector: a wrong preset, bit order or output mask returns something other than 0x51DF.
- High bits on data writes: if those bits leaked into the fold, the check value would differ from the same stream written with clean bytes.
- Back-to-back streaming: a design that drops a byte under pressure would show a short count.
- Saturation run past 0xFFF: a wrapping counter would read a small value.
- Clear right after a data write: if the pending byte were allowed to land, the count would be 1 instead of 0.
- Clear bit deasserted and the reserved address: a decoder that treats these as live would disturb the count or output.

// File: rtl/fcs_crc_pkg.sv
package fcs_crc_pkg;
    localparam int REG_W  = 16;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_RSVD = 2'd2,
        SEL_OUT  = 2'd3
    } reg_sel_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ABSORB = 1'b1
    } seq_state_e;
endpackage

// File: rtl/fcs_crc_byte_fold.sv
module fcs_crc_byte_fold
    import fcs_crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] FEEDBACK = 16'h8408
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] work;

    // One bit per iteration, least-significant bit of the byte first.
    always_comb begin
        work = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};
        for (int b = 0; b < BYTE_W; b++) begin
            if (work[0]) begin
                work = (work >> 1) ^ FEEDBACK;
            end else begin
                work = work >> 1;
            end
        end
        crc_out = work;
    end
endmodule

// File: rtl/fcs_crc_seq.sv
module fcs_crc_seq
    import fcs_crc_pkg::*;
#(
    parameter int               CNT_W    = 12,
    parameter logic [CRC_W-1:0] PRESET   = 16'h0000,
    parameter logic [CRC_W-1:0] FEEDBACK = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              byte_req,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              absorbing
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] hold_q;
    logic [CRC_W-1:0]  folded;

    fcs_crc_byte_fold #(.FEEDBACK(FEEDBACK)) u_fold (
        .crc_in  (acc_q),
        .byte_in (hold_q),
        .crc_out (folded)
    );

    // Next-state logic; a clear always returns to IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = byte_req ? ST_ABSORB : ST_IDLE;
            ST_ABSORB: state_d = byte_req ? ST_ABSORB : ST_IDLE;
        endcase
        if (clr_req) begin
            state_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output / datapath registers driven by the current state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= PRESET;
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            if (byte_req) begin
                hold_q <= byte_in;
            end
            if (clr_req) begin
                acc_q <= PRESET;
                cnt_q <= '0;
            end else if (state_q == ST_ABSORB) begin
                acc_q <= folded;
                cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            end
        end
    end

    assign absorbing = (state_q == ST_ABSORB);
endmodule

// File: rtl/fcs_crc_regport.sv
module fcs_crc_regport
    import fcs_crc_pkg::*;
#(
    parameter int               CNT_W   = 12,
    parameter int               CLR_BIT = 15,
    parameter logic [CRC_W-1:0] XOROUT  = 16'hFCDE
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CRC_W-1:0]  acc,
    input  logic [CNT_W-1:0]  cnt,
    output logic              clr_req,
    output logic              byte_req,
    output logic [BYTE_W-1:0] byte_val,
    output logic [REG_W-1:0]  rd_data
);
    localparam int PAD_W = REG_W - CNT_W;

    assign clr_req  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_data[CLR_BIT];
    assign byte_req = wr_en && (reg_sel_e'(wr_addr) == SEL_DATA);
    assign byte_val = wr_data[BYTE_W-1:0];

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = {{PAD_W{1'b0}}, cnt};
            SEL_DATA: rd_data = '0;
            SEL_RSVD: rd_data = '0;
            SEL_OUT:  rd_data = acc ^ XOROUT;
        endcase
    end
endmodule

// File: rtl/fcs_crc_engine.sv
module fcs_crc_engine
    import fcs_crc_pkg::*;
#(
    parameter int               CNT_W    = 12,
    parameter int               CLR_BIT  = 15,
    parameter logic [CRC_W-1:0] PRESET   = 16'h0000,
    parameter logic [CRC_W-1:0] XOROUT   = 16'hFCDE,
    parameter logic [CRC_W-1:0] FEEDBACK = 16'h8408
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data
);
    logic              clr_req;
    logic              byte_req;
    logic [BYTE_W-1:0] byte_val;
    logic [CRC_W-1:0]  acc_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              absorbing_w;

    fcs_crc_regport #(
        .CNT_W   (CNT_W),
        .CLR_BIT (CLR_BIT),
        .XOROUT  (XOROUT)
    ) u_port (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .acc      (acc_w),
        .cnt      (cnt_w),
        .clr_req  (clr_req),
        .byte_req (byte_req),
        .byte_val (byte_val),
        .rd_data  (rd_data)
    );

    fcs_crc_seq #(
        .CNT_W    (CNT_W),
        .PRESET   (PRESET),
        .FEEDBACK (FEEDBACK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (clr_req),
        .byte_req  (byte_req),
        .byte_in   (byte_val),
        .acc_q     (acc_w),
        .cnt_q     (cnt_w),
        .absorbing (absorbing_w)
    );
endmodule

// File: rtl/fcs_crc_checker.sv
module fcs_crc_checker #(
    parameter int          CNT_W   = 12,
    parameter int          CLR_BIT = 15,
    parameter logic [15:0] PRESET  = 16'h0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [15:0]      wr_data,
    input logic [1:0]       rd_addr,
    input logic [15:0]      rd_data,
    input logic [15:0]      acc,
    input logic [CNT_W-1:0] cnt,
    input logic             absorbing
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic clr_seen;
    assign clr_seen = wr_en && (wr_addr == 2'd0) && wr_data[CLR_BIT];

    // R1, R11: a clear lands on the next edge regardless of pending bytes
    a_r1_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        clr_seen |=> (cnt == '0) && (acc == PRESET));

    // R4: an absorb cycle advances the count by one unless at the top
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (absorbing && !clr_seen) |=>
            (cnt == (($past(cnt) == CNT_TOP) ? $past(cnt) : $past(cnt) + 1'b1)));

    // R5: the count holds at its ceiling
    a_r5_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_TOP) && !clr_seen) |=> (cnt == CNT_TOP));

    // R8: reserved address reads zero
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd2) |-> (rd_data == 16'h0000));

    // R2: upper control bits read zero
    a_r2_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> (rd_data[15:CNT_W] == '0));

    // R8, R1: with nothing to absorb and no write, state is frozen
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!absorbing && !wr_en) |=> ($stable(acc) && $stable(cnt)));
endmodule

bind fcs_crc_engine fcs_crc_checker #(
    .CNT_W   (CNT_W),
    .CLR_BIT (CLR_BIT),
    .PRESET  (PRESET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .acc       (acc_w),
    .cnt       (cnt_w),
    .absorbing (absorbing_w)
);

// File: tb/fcs_crc_engine_bench.sv
module fcs_crc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0000;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [15:0] m_acc;
    logic [11:0] m_cnt;
    logic [15:0] got;

    always #5 clk = ~clk;

    fcs_crc_engine u_fcs_crc_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Vector: {use_literal, data16, expected_out16}
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 16'h00CC, 16'h0000},
        {1'b0, 16'h00F5, 16'h0000},
        {1'b0, 16'h00F1, 16'h0000},
        {1'b1, 16'h00A7, 16'h51DF},
        {1'b0, 16'h0012, 16'h0000},
        {1'b0, 16'h00FF, 16'h0000},
        {1'b0, 16'h0000, 16'h0000},
        {1'b0, 16'h0081, 16'h0000}
    };

    function automatic logic [15:0] m_fold(logic [15:0] c, logic [7:0] d);
        logic [15:0] w;
        w = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            w = w[0] ? ((w >> 1) ^ 16'h8408) : (w >> 1);
        end
        return w;
    endfunction

    task automatic model_byte(input logic [7:0] d);
        m_acc = m_fold(m_acc, d);
        if (m_cnt != 12'hFFF) m_cnt = m_cnt + 1'b1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives for exactly one rising edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clear();
        wr(2'd0, 16'h8000);
        m_acc = 16'h0000;
        m_cnt = 12'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_acc = 16'h0000;
        m_cnt = 12'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, got); check("R10 count", got, 16'h0000);
        rd(2'd3, got); check("R10 out", got, 16'hFCDE);

        // Table walk: R6 self-test vector then R7 model continuation
        clear();
        rd(2'd3, got); check("R1 out after clear", got, 16'hFCDE);
        for (int v = 0; v < 8; v++) begin
            wr(2'd1, VEC[v][31:16]);
            @(negedge clk);
            model_byte(VEC[v][23:16]);
            rd(2'd0, got); check("R4 count per write", got, {4'h0, m_cnt});
            rd(2'd3, got);
            if (VEC[v][32]) check("R6 self-test out", got, VEC[v][15:0]);
            else            check("R7 out vs model", got, m_acc ^ 16'hFCDE);
            if (v == 3) begin
                rd(2'd0, got); check("R6 self-test count", got, 16'h0004);
            end
        end

        // R4 back-to-back streaming
        clear();
        wr(2'd1, 16'h0031); wr(2'd1, 16'h0042); wr(2'd1, 16'h0053);
        @(negedge clk);
        model_byte(8'h31); model_byte(8'h42); model_byte(8'h53);
        rd(2'd0, got); check("R4 streamed count", got, 16'h0003);
        rd(2'd3, got); check("R4 streamed out", got, m_acc ^ 16'hFCDE);

        // R3 high bits ignored
        clear();
        wr(2'd1, 16'hFFCC); wr(2'd1, 16'h0AF5);
        @(negedge clk);
        model_byte(8'hCC); model_byte(8'hF5);
        rd(2'd3, got); check("R3 upper bits ignored", got, m_acc ^ 16'hFCDE);

        // R1 control write without clear bit has no effect
        wr(2'd0, 16'h7FFF);
        @(negedge clk);
        rd(2'd0, got); check("R1 no-clear count", got, 16'h0002);
        rd(2'd3, got); check("R1 no-clear out", got, m_acc ^ 16'hFCDE);

        // R8 reserved register
        wr(2'd2, 16'hFFFF);
        @(negedge clk);
        rd(2'd2, got); check("R8 reserved reads zero", got, 16'h0000);
        rd(2'd0, got); check("R8 count untouched", got, 16'h0002);
        rd(2'd3, got); check("R8 out untouched", got, m_acc ^ 16'hFCDE);

        // R11 clear right after data write wins
        wr(2'd1, 16'h0055);
        wr(2'd0, 16'h8000);
        m_acc = 16'h0000; m_cnt = 12'd0;
        @(negedge clk);
        rd(2'd0, got); check("R11 count after clear", got, 16'h0000);
        rd(2'd3, got); check("R11 out after clear", got, 16'hFCDE);

        // R5 saturation, R2 upper bits zero
        clear();
        for (int n = 0; n < 4100; n++) begin
            wr(2'd1, {8'h00, n[7:0]});
            model_byte(n[7:0]);
        end
        @(negedge clk);
        rd(2'd0, got); check("R5 count saturates", got, 16'h0FFF);
        check("R2 upper control bits", {got[15:12], 12'h000}, 16'h0000);
        rd(2'd3, got); check("R5 out keeps updating", got, m_acc ^ 16'hFCDE);

        // R9 read is combinational: switch address, read same cycle
        rd(2'd2, got); check("R9 comb read reserved", got, 16'h0000);
        rd(2'd0, got); check("R9 comb read ctrl", got, 16'h0FFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule